// File: doc/BRIEF.md
# Nested-List Frame Packer

This block sits at the sending end of a streaming link on which neither side can hold a whole list in memory. It takes a stream of phit-wide items. Each item carries the nesting depth of its data, or is marked as a list-end event. The block turns the stream into an outgoing phit stream. Items at depth one or more are collected into frames, and each frame is sent behind a one-phit header that gives its length and depth. Items at depth zero go out bare, as single phits, in their place in the order.

A frame is sealed when it holds `FRAME_MAX` phits, when an item at a different depth arrives, or when a list ends. A list end always produces a header with size zero, so the receiver learns where the list terminates without any marker field inside the data. Sealed frames wait in a data ring that is two frames deep, and their headers wait in a small queue of their own. The next frame can therefore fill while the previous one is leaving the block.

Top module: `frame_packer`

## Requirements
- R1: After reset `outValid` is low and no frame is open.
- R2: A frame goes out as a header phit followed by exactly `size` data phits, in the order they were accepted. The header holds the size in bits 15:0 and the depth, zero-extended, in bits 23:16. All higher bits are zero.
- R3: An open frame that already holds `FRAME_MAX` phits is sealed before another item at the same depth is accepted. That item then starts a new frame.
- R4: A data item at a depth different from that of a non-empty open frame is accepted only after the open frame has been sealed. All phits of a frame share one depth.
- R5: A list-end event seals any non-empty open frame first. It then emits a header of size zero that carries the depth given with the event.
- R6: A depth-zero data item is sent as a single bare phit with no header. This happens only after any open frame has been sealed, so the item appears after that frame's data.
- R7: No phit is lost, duplicated or reordered under output backpressure. While `outValid` is high and `outReady` is low, `outValid` and `outData` hold their values.
- R8: With the output fully stalled, the block accepts exactly `2*FRAME_MAX` data phits of one long list before `inReady` stays low. One sealed frame waits to drain while the next frame fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input item present |
| inReady | output | 1 | Input item accepted this cycle |
| inListEnd | input | 1 | Item is a list-end event; `inData` is ignored |
| inLevel | input | LEVEL_W | Nesting depth of the item or of the ending list |
| inData | input | PHIT_W | Item data |
| outValid | output | 1 | Output phit present |
| outReady | input | 1 | Downstream takes the output phit |
| outData | output | PHIT_W | Header or data phit |

## Verification
The hardest situation to reach is the one in which both storage regions are occupied: one sealed frame of full length is parked behind a stalled output while a second frame fills to its limit. Only then does the room check on the data ring, and not the frame-length check, stop the input. The bench creates this case by holding `outReady` low for many cycles while it feeds one long list. It counts how many items are taken before the input stalls, then releases the output and checks that the whole backlog comes out in order. The other corner cases are reached by input sequences that mix depths and list ends: an empty list, a frame that is cut at exactly `FRAME_MAX`, and a depth-zero item that arrives while a frame is open. These sequences are also repeated under an irregular pattern of `outReady`.

// File: rtl/frame_packer_pkg.sv
package frame_packer_pkg;
  localparam int SIZE_W = 16;
  localparam int LVL_FIELD_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                   dataPush;
    logic                   hdrPush;
    logic                   hdrRaw;
    logic [LVL_FIELD_W-1:0] hdrLevel;
    logic [SIZE_W-1:0]      hdrSize;
  } strobe_t;
endpackage

// File: rtl/frame_packer_fifo.sv
module frame_packer_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout = mem[rdPtr];
endmodule

// File: rtl/frame_packer_ctrl.sv
module frame_packer_ctrl
  import frame_packer_pkg::*;
#(
  parameter int LEVEL_W   = 4,
  parameter int FRAME_MAX = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               inListEnd,
  input  logic [LEVEL_W-1:0] inLevel,
  output logic               inReady,
  input  logic               dataRoom,
  input  logic               hdrRoom,
  output strobe_t            stb
);
  localparam int CW = $clog2(FRAME_MAX+1);

  logic [CW-1:0]      openCount;
  logic [LEVEL_W-1:0] openLevel;
  logic               closeNow;
  logic               accept;

  always_comb begin
    closeNow = 1'b0;
    accept   = 1'b0;
    stb      = '0;
    if (inValid) begin
      if (inListEnd) begin
        if (openCount != '0) closeNow = hdrRoom;
        else if (hdrRoom) begin
          accept       = 1'b1;
          stb.hdrPush  = 1'b1;
          stb.hdrLevel = LVL_FIELD_W'(inLevel);
        end
      end else if (inLevel == '0) begin
        if (openCount != '0) closeNow = hdrRoom;
        else if (hdrRoom && dataRoom) begin
          accept       = 1'b1;
          stb.hdrPush  = 1'b1;
          stb.hdrRaw   = 1'b1;
          stb.hdrSize  = SIZE_W'(1);
          stb.dataPush = 1'b1;
        end
      end else if (openCount != '0 &&
                   (inLevel != openLevel || openCount == CW'(FRAME_MAX))) begin
        closeNow = hdrRoom;
      end else if (dataRoom) begin
        accept       = 1'b1;
        stb.dataPush = 1'b1;
      end
    end
    if (closeNow) begin
      stb.hdrPush  = 1'b1;
      stb.hdrSize  = SIZE_W'(openCount);
      stb.hdrLevel = LVL_FIELD_W'(openLevel);
    end
  end

  assign inReady = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      openCount <= '0;
      openLevel <= '0;
    end else if (closeNow) begin
      openCount <= '0;
    end else if (accept && !inListEnd && inLevel != '0) begin
      openCount <= openCount + 1'b1;
      openLevel <= inLevel;
    end
  end
endmodule

// File: rtl/frame_packer_dp.sv
module frame_packer_dp
  import frame_packer_pkg::*;
#(
  parameter int PHIT_W     = 32,
  parameter int DATA_DEPTH = 512,
  parameter int HDR_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [PHIT_W-1:0] inData,
  output logic              dataRoom,
  output logic              hdrRoom,
  output logic              outValid,
  input  logic              outReady,
  output logic [PHIT_W-1:0] outData
);
  localparam int HW  = 1 + LVL_FIELD_W + SIZE_W;
  localparam int DCW = $clog2(DATA_DEPTH+1);
  localparam int HCW = $clog2(HDR_DEPTH+1);

  logic [PHIT_W-1:0] dataHead;
  logic [DCW-1:0]    dCount;
  logic [HW-1:0]     hdrHead;
  logic [HCW-1:0]    hCount;
  logic              popD, popH;
  logic [SIZE_W-1:0] bodyLeft;
  logic              hRaw;
  logic [LVL_FIELD_W-1:0] hLevel;
  logic [SIZE_W-1:0] hSize;
  logic [PHIT_W-1:0] hdrPhit;

  frame_packer_fifo #(.W(PHIT_W), .DEPTH(DATA_DEPTH)) u_data (
    .clk(clk), .rst(rst), .push(stb.dataPush), .din(inData),
    .pop(popD), .dout(dataHead), .count(dCount));

  frame_packer_fifo #(.W(HW), .DEPTH(HDR_DEPTH)) u_hdr (
    .clk(clk), .rst(rst), .push(stb.hdrPush),
    .din({stb.hdrRaw, stb.hdrLevel, stb.hdrSize}),
    .pop(popH), .dout(hdrHead), .count(hCount));

  assign dataRoom = dCount < DCW'(DATA_DEPTH);
  assign hdrRoom  = hCount < HCW'(HDR_DEPTH);
  assign {hRaw, hLevel, hSize} = hdrHead;

  always_comb begin
    hdrPhit = '0;
    hdrPhit[SIZE_W-1:0] = hSize;
    hdrPhit[SIZE_W +: LVL_FIELD_W] = hLevel;
  end

  always_comb begin
    outValid = 1'b0;
    outData  = dataHead;
    popD     = 1'b0;
    popH     = 1'b0;
    if (bodyLeft != '0) begin
      outValid = dCount != '0;
      popD     = outValid && outReady;
    end else if (hCount != '0) begin
      if (hRaw) begin
        outValid = dCount != '0;
        popD     = outValid && outReady;
        popH     = popD;
      end else begin
        outValid = 1'b1;
        outData  = hdrPhit;
        popH     = outReady;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bodyLeft <= '0;
    else if (bodyLeft != '0) begin
      if (popD) bodyLeft <= bodyLeft - 1'b1;
    end else if (popH && !hRaw) bodyLeft <= hSize;
  end
endmodule

// File: rtl/frame_packer.sv
module frame_packer
  import frame_packer_pkg::*;
#(
  parameter int PHIT_W    = 32,
  parameter int LEVEL_W   = 4,
  parameter int FRAME_MAX = 256,
  parameter int HDR_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic               inListEnd,
  input  logic [LEVEL_W-1:0] inLevel,
  input  logic [PHIT_W-1:0]  inData,
  output logic               outValid,
  input  logic               outReady,
  output logic [PHIT_W-1:0]  outData
);
  localparam int DATA_DEPTH = 2 * FRAME_MAX;

  strobe_t stb;
  logic    dataRoom, hdrRoom;

  frame_packer_ctrl #(.LEVEL_W(LEVEL_W), .FRAME_MAX(FRAME_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inListEnd(inListEnd),
    .inLevel(inLevel), .inReady(inReady), .dataRoom(dataRoom),
    .hdrRoom(hdrRoom), .stb(stb));

  frame_packer_dp #(.PHIT_W(PHIT_W), .DATA_DEPTH(DATA_DEPTH),
                    .HDR_DEPTH(HDR_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .inData(inData),
    .dataRoom(dataRoom), .hdrRoom(hdrRoom), .outValid(outValid),
    .outReady(outReady), .outData(outData));
endmodule

// File: rtl/frame_packer_checker.sv
module frame_packer_checker #(
  parameter int PHIT_W    = 32,
  parameter int LEVEL_W   = 4,
  parameter int FRAME_MAX = 256
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         inValid,
  input logic                         inReady,
  input logic                         inListEnd,
  input logic [LEVEL_W-1:0]           inLevel,
  input logic                         outValid,
  input logic                         outReady,
  input logic [PHIT_W-1:0]            outData,
  input logic [$clog2(FRAME_MAX+1)-1:0] openCount,
  input logic [LEVEL_W-1:0]           openLevel
);
  logic takeData;
  assign takeData = inValid && inReady && !inListEnd;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData)); // R7
  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (rst)
    openCount <= ($clog2(FRAME_MAX+1))'(FRAME_MAX)); // R3
  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    takeData && inLevel != '0 && openCount != '0 |-> inLevel == openLevel); // R4
  AST_END_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && inListEnd |-> openCount == '0); // R5
  AST_RAW_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    takeData && inLevel == '0 |-> openCount == '0); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    $fell(rst) |-> !outValid && openCount == '0); // R1
endmodule

bind frame_packer frame_packer_checker #(
  .PHIT_W(PHIT_W), .LEVEL_W(LEVEL_W), .FRAME_MAX(FRAME_MAX)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .inListEnd(inListEnd), .inLevel(inLevel), .outValid(outValid),
  .outReady(outReady), .outData(outData),
  .openCount(u_ctrl.openCount), .openLevel(u_ctrl.openLevel));

// File: tb/frame_packer_bench.sv
module frame_packer_bench;
  localparam int PHIT_W = 32;
  localparam int LEVEL_W = 4;
  localparam int MAXF = 4;

  logic clk = 0, rst = 1;
  logic inValid = 0, inListEnd = 0, outReady = 1;
  logic [LEVEL_W-1:0] inLevel = '0;
  logic [PHIT_W-1:0] inData = '0;
  logic inReady, outValid;
  logic [PHIT_W-1:0] outData;

  int checks = 0, errors = 0, acceptCount = 0, seq = 0, cyc = 0, readyMode = 0;
  logic [PHIT_W-1:0] exp[$];
  string expTag[$];
  logic [PHIT_W-1:0] cur[$];
  int curLevel = 0;

  always #4 clk = ~clk;

  frame_packer #(.PHIT_W(PHIT_W), .LEVEL_W(LEVEL_W), .FRAME_MAX(MAXF),
                 .HDR_DEPTH(4)) u_frame_packer (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inListEnd(inListEnd), .inLevel(inLevel), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData));

  function automatic logic [PHIT_W-1:0] hdr(int size, int lvl);
    logic [PHIT_W-1:0] h = '0;
    h[15:0] = 16'(size);
    h[23:16] = 8'(lvl);
    return h;
  endfunction

  function automatic void flush(string tag);
    if (cur.size() > 0) begin
      exp.push_back(hdr(cur.size(), curLevel)); expTag.push_back(tag);
      foreach (cur[i]) begin exp.push_back(cur[i]); expTag.push_back("R2"); end
      cur.delete();
    end
  endfunction

  function automatic void modelItem(logic [PHIT_W-1:0] d, int lvl, bit isEnd);
    if (isEnd) begin
      flush("R5"); exp.push_back(hdr(0, lvl)); expTag.push_back("R5");
    end else if (lvl == 0) begin
      flush("R6"); exp.push_back(d); expTag.push_back("R6");
    end else begin
      if (cur.size() > 0 && lvl != curLevel) flush("R4");
      else if (cur.size() == MAXF) flush("R3");
      cur.push_back(d); curLevel = lvl;
    end
  endfunction

  task automatic send(int lvl, bit isEnd);
    logic [PHIT_W-1:0] d = 32'hA000_0000 + PHIT_W'(seq);
    seq++;
    @(negedge clk);
    inValid = 1; inLevel = LEVEL_W'(lvl); inListEnd = isEnd; inData = d;
    forever begin
      #1;
      if (inReady) break;
      @(negedge clk);
    end
    modelItem(d, lvl, isEnd);
    acceptCount++;
  endtask

  task automatic idle();
    @(negedge clk); inValid = 0; inListEnd = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp.size() > 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (readyMode == 0) outReady <= 1;
    else if (readyMode == 1) outReady <= (cyc % 3) != 0;
    else outReady <= 0;
  end

  always @(negedge clk) begin
    #1;
    if (!rst && outValid && outReady) begin
      checks++;
      if (exp.size() == 0) begin
        errors++; $display("FAIL R7 extra phit actual %h expected none", outData);
      end else begin
        if (outData !== exp[0]) begin
          errors++;
          $display("FAIL %s actual %h expected %h", expTag[0], outData, exp[0]);
        end
        void'(exp.pop_front()); void'(expTag.pop_front());
      end
    end
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; $display("FAIL watchdog expired actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    checks++;
    if (outValid !== 1'b0) begin errors++; $display("FAIL R1 outValid actual %b expected 0", outValid); end

    // R2 R5: short list
    for (int i = 0; i < 3; i++) send(1, 0);
    send(1, 1); idle(); drain();
    // R5: empty list
    send(2, 1); idle(); drain();
    // R3: list longer than a frame
    for (int i = 0; i < 6; i++) send(1, 0);
    send(1, 1); idle(); drain();
    // R4: nested list changes depth
    send(1, 0); send(1, 0);
    for (int i = 0; i < 3; i++) send(2, 0);
    send(2, 1); send(1, 0); send(1, 1); idle(); drain();
    // R6: bare item with an open frame
    send(1, 0); send(1, 0); send(0, 0); send(1, 0); send(1, 1); send(0, 0);
    idle(); drain();
    // R7: irregular backpressure
    readyMode = 1;
    for (int i = 0; i < 9; i++) send(1 + (i % 3 == 2 ? 1 : 0), 0);
    send(2, 1); send(0, 0); send(1, 1); idle(); drain();
    readyMode = 0;
    // R8: stalled output, one long list
    readyMode = 2; repeat (2) @(negedge clk);
    acceptCount = 0;
    fork
      begin
        for (int i = 0; i < 2 * MAXF + 2; i++) send(3, 0);
        send(3, 1); idle();
      end
      begin
        repeat (40) @(negedge clk);
        #2;
        checks++;
        if (acceptCount != 2 * MAXF) begin
          errors++;
          $display("FAIL R8 accepted actual %0d expected %0d", acceptCount, 2 * MAXF);
        end
        readyMode = 0;
      end
    join
    drain();
    checks++;
    if (exp.size() != 0) begin
      errors++; $display("FAIL R7 pending phits actual %0d expected 0", exp.size());
    end
    finishRun();
  end
endmodule